// File: doc/BRIEF.md
# Peripheral Bus Access Extender

This block connects a CPU-side memory bus to eight slow peripherals. A request whose address falls inside a peripheral window of eight consecutive 1 KB regions is turned into a one-hot select for the matching region. The block then holds that access on the peripheral side for a programmable number of system clocks, from 2 to 16. This emulates an interface clock divided down from the system clock. The CPU sees a wait indication until the final cycle, and in that cycle it sees ready. Read data is taken from the selected peripheral in that final cycle.

A request is a single-cycle strobe on `cpu_req`, taken only while the block is idle. The divide ratio is sampled once, when a request is accepted. An address outside the window produces no select and answers at once with a decode-error response. The peripheral side also gets a single-cycle enable that marks the interface-clock edge at the end of each stretched access.

Top module: `perif_access_ext`

## Requirements
- R1: After reset, `per_sel`, `per_we`, `per_clk_en`, `cpu_wait`, `cpu_ready` and `cpu_err` are all 0.
- R2: An accepted address A with 0 <= A-BASE < 8*1024 (BASE default 0x4000) asserts only `per_sel[(A-BASE)>>10]`. It also drives `per_addr` = A[9:0]. Both hold unchanged for every cycle of the access.
- R3: With a divide ratio N, an access keeps its select for exactly N cycles, starting the cycle after acceptance. `cpu_wait` is 1 in the first N-1 of those cycles. `cpu_ready` is 1 only in the Nth. The select drops in the following cycle.
- R4: The 5-bit `cfg_div` is clamped: values 0 and 1 act as 2, and values above 16 act as 16.
- R5: A change of `cfg_div` during an access does not alter that access's length. The next accepted access uses the new value.
- R6: For a read, `cpu_rdata` in the ready cycle equals the selected lane of `per_rdata` (lane i at bits [32*i+31:32*i]). `per_we` stays 0 throughout the access. `cpu_rdata` is 0 whenever `cpu_ready` is 0.
- R7: For a write, `per_we` is 1 for every cycle of the access. `per_wdata` equals the `cpu_wdata` captured at acceptance.
- R8: An address outside the window asserts no select and no wait. In the cycle after acceptance it gives `cpu_ready`=1 with `cpu_err`=1, and the block is idle one cycle later.
- R9: `cpu_req` and a new `cpu_addr` presented while an access is in progress, including its ready cycle, are ignored. The select, offset and length of the running access are unchanged, and no access follows it.
- R10: `per_clk_en` pulses exactly once per in-window access, in its ready cycle. It never pulses for a decode-error access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div | input | 5 | Interface-clock divide ratio, clamped to 2..16 |
| cpu_req | input | 1 | Single-cycle access request, taken when idle |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | CPU byte address |
| cpu_wdata | input | 32 | CPU write data |
| cpu_wait | output | 1 | Access in progress, not yet complete |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_err | output | 1 | Decode error, valid with ready |
| cpu_rdata | output | 32 | Read data, valid with ready on a read |
| per_sel | output | 8 | One-hot peripheral select |
| per_addr | output | 10 | Byte offset inside the selected region |
| per_wdata | output | 32 | Write data to peripheral |
| per_we | output | 1 | Write enable for the whole access |
| per_clk_en | output | 1 | Interface-clock enable, final cycle of an access |
| per_rdata | input | 256 | Read data, one 32-bit lane per peripheral |

## Verification
An in-window access accepted at edge E shows its select from the cycle after E. Its ready and interface enable appear N cycles after E, and the select is gone at N+1. A decode-error response appears one cycle after E and is gone by two. The bench drives inputs between edges and samples 2 ns after each rising edge. It walks an access cycle by cycle: it counts the wait cycles and enable pulses, checks select, offset, write enable and write data in each cycle, and compares the cycle of ready with the clamped ratio it works out itself. After each access it checks one more cycle to confirm that the block has returned to idle.

// File: rtl/pax_pkg.sv
package pax_pkg;

  // Clamp a raw divide request into the supported range.
  function automatic int unsigned clamp_div(input int unsigned raw,
                                            input int unsigned lo,
                                            input int unsigned hi);
    if (raw < lo) return lo;
    if (raw > hi) return hi;
    return raw;
  endfunction

  // Count value of the final cycle of an access stretched by div.
  function automatic int unsigned final_count(input int unsigned div);
    return div - 1;
  endfunction

  // Region index of a window-relative address.
  function automatic int unsigned region_of(input int unsigned rel,
                                            input int unsigned region_w);
    return rel >> region_w;
  endfunction

endpackage

// File: rtl/pax_decode.sv
module pax_decode #(
  parameter int ADDR_W   = 16,
  parameter int REGION_W = 10,
  parameter int SEL_N    = 8,
  parameter logic [ADDR_W-1:0] BASE = 16'h4000
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic                hit,
  output logic [SEL_N-1:0]    sel_vec,
  output logic [REGION_W-1:0] offset
);
  import pax_pkg::*;

  localparam int SEL_W = $clog2(SEL_N);
  localparam logic [ADDR_W:0] WIN = (ADDR_W+1)'(SEL_N) << REGION_W;

  logic [ADDR_W-1:0] rel;
  logic [SEL_W-1:0]  idx;

  assign rel    = addr - BASE;
  assign hit    = {1'b0, rel} < WIN;
  assign idx    = SEL_W'(region_of(32'(rel), REGION_W));
  assign offset = rel[REGION_W-1:0];

  for (genvar i = 0; i < SEL_N; i++) begin : g_sel
    assign sel_vec[i] = hit && (idx == SEL_W'(i));
  end

endmodule

// File: rtl/pax_pacer.sv
module pax_pacer #(
  parameter int DIV_W   = 5,
  parameter int DIV_MIN = 2,
  parameter int DIV_MAX = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DIV_W-1:0] cfg_div,
  output logic             active,
  output logic             last
);
  import pax_pkg::*;

  localparam int CNT_W = $clog2(DIV_MAX + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] div_lat;
  logic [CNT_W-1:0] div_now;

  assign div_now = CNT_W'(clamp_div(32'(cfg_div), DIV_MIN, DIV_MAX));
  assign last    = active && (cnt == CNT_W'(final_count(32'(div_lat))));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      cnt     <= '0;
      div_lat <= CNT_W'(DIV_MIN);
    end else if (start) begin
      active  <= 1'b1;
      cnt     <= '0;
      div_lat <= div_now;
    end else if (active) begin
      if (last) begin
        active <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (div_lat >= CNT_W'(DIV_MIN)) && (div_lat <= CNT_W'(DIV_MAX))); // R4
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt < div_lat)); // R3
  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !last) |=> $stable(div_lat)); // R5
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> !start); // R9

endmodule

// File: rtl/pax_rdmux.sv
module pax_rdmux #(
  parameter int SEL_N  = 8,
  parameter int DATA_W = 32
) (
  input  logic [SEL_N-1:0]        sel,
  input  logic [SEL_N*DATA_W-1:0] lanes,
  output logic [DATA_W-1:0]       rdata
);
  logic [DATA_W-1:0] masked [SEL_N];

  for (genvar i = 0; i < SEL_N; i++) begin : g_lane
    assign masked[i] = {DATA_W{sel[i]}} & lanes[i*DATA_W +: DATA_W];
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < SEL_N; i++) rdata = rdata | masked[i];
  end

endmodule

// File: rtl/perif_access_ext.sv
module perif_access_ext #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int REGION_W = 10,
  parameter int SEL_N    = 8,
  parameter int DIV_W    = 5,
  parameter int DIV_MIN  = 2,
  parameter int DIV_MAX  = 16,
  parameter logic [ADDR_W-1:0] BASE = 16'h4000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [DIV_W-1:0]        cfg_div,
  input  logic                    cpu_req,
  input  logic                    cpu_write,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic [DATA_W-1:0]       cpu_wdata,
  output logic                    cpu_wait,
  output logic                    cpu_ready,
  output logic                    cpu_err,
  output logic [DATA_W-1:0]       cpu_rdata,
  output logic [SEL_N-1:0]        per_sel,
  output logic [REGION_W-1:0]     per_addr,
  output logic [DATA_W-1:0]       per_wdata,
  output logic                    per_we,
  output logic                    per_clk_en,
  input  logic [SEL_N*DATA_W-1:0] per_rdata
);

  // Named internal events
  logic                hit;
  logic [SEL_N-1:0]    sel_vec;
  logic [REGION_W-1:0] offset;
  logic                busy;
  logic                accept;
  logic                start;
  logic                active;
  logic                last;
  logic                err_q;
  logic                we_q;
  logic [SEL_N-1:0]    sel_q;
  logic [REGION_W-1:0] addr_q;
  logic [DATA_W-1:0]   wdata_q;
  logic [DATA_W-1:0]   lane_rdata;

  pax_decode #(
    .ADDR_W(ADDR_W), .REGION_W(REGION_W), .SEL_N(SEL_N), .BASE(BASE)
  ) u_dec (
    .addr(cpu_addr), .hit(hit), .sel_vec(sel_vec), .offset(offset)
  );

  assign busy   = active || err_q;
  assign accept = cpu_req && !busy;
  assign start  = accept && hit;

  pax_pacer #(
    .DIV_W(DIV_W), .DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX)
  ) u_pace (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_div(cfg_div),
    .active(active), .last(last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q   <= 1'b0;
      we_q    <= 1'b0;
      sel_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      err_q <= accept && !hit;
      if (start) begin
        sel_q   <= sel_vec;
        addr_q  <= offset;
        wdata_q <= cpu_wdata;
        we_q    <= cpu_write;
      end else if (last) begin
        sel_q <= '0;
        we_q  <= 1'b0;
      end
    end
  end

  pax_rdmux #(.SEL_N(SEL_N), .DATA_W(DATA_W)) u_rd (
    .sel(sel_q), .lanes(per_rdata), .rdata(lane_rdata)
  );

  assign cpu_wait   = active && !last;
  assign cpu_ready  = last || err_q;
  assign cpu_err    = err_q;
  assign cpu_rdata  = (last && !we_q) ? lane_rdata : '0;
  assign per_sel    = sel_q;
  assign per_addr   = addr_q;
  assign per_wdata  = wdata_q;
  assign per_we     = we_q;
  assign per_clk_en = last;

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(per_sel)); // R2
  AST_SEL_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (per_sel != '0)); // R2
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !last) |=> ($stable(per_sel) && $stable(per_addr))); // R9
  AST_SEL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && !cpu_err) |=> (per_sel == '0)); // R3
  AST_WAIT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_wait && cpu_ready)); // R3
  AST_ERR_NOSEL: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_err |-> ((per_sel == '0) && cpu_ready && !cpu_wait)); // R8
  AST_ERR_ONECYC: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_err |=> !cpu_err); // R8
  AST_WE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    per_we |-> (per_sel != '0)); // R7
  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_ready |-> (cpu_rdata == '0)); // R6
  AST_CLKEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    per_clk_en |-> (cpu_ready && !cpu_err)); // R10

endmodule

// File: tb/sim_perif_access_ext.sv
`timescale 1ns/1ps
module sim_perif_access_ext;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [4:0]   cfg_div = 5'd2;
  logic         cpu_req = 1'b0;
  logic         cpu_write = 1'b0;
  logic [15:0]  cpu_addr = '0;
  logic [31:0]  cpu_wdata = '0;
  logic         cpu_wait, cpu_ready, cpu_err, per_we, per_clk_en;
  logic [31:0]  cpu_rdata, per_wdata;
  logic [7:0]   per_sel;
  logic [9:0]   per_addr;
  logic [255:0] per_rdata;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;  // 125 MHz

  // Peripheral model: lane i answers C0ii_0000 | offset
  always_comb begin
    for (int i = 0; i < 8; i++)
      per_rdata[i*32 +: 32] = 32'hC000_0000 | (32'(i) << 16) | 32'(per_addr);
  end

  perif_access_ext u0 (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cpu_req(cpu_req),
    .cpu_write(cpu_write), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wait(cpu_wait), .cpu_ready(cpu_ready), .cpu_err(cpu_err),
    .cpu_rdata(cpu_rdata), .per_sel(per_sel), .per_addr(per_addr),
    .per_wdata(per_wdata), .per_we(per_we), .per_clk_en(per_clk_en),
    .per_rdata(per_rdata)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_div(input int raw);
    return (raw < 2) ? 2 : (raw > 16) ? 16 : raw;
  endfunction

  // mode 0: plain; 1: change cfg_div to new_div in cycle 2; 2: hammer requests
  task automatic access(input logic [15:0] a, input logic w, input logic [31:0] d,
                        input int exp_n, input int mode, input int new_div,
                        input string req);
    int cyc = 0, waits = 0, ens = 0, bad = 0;
    bit got = 0;
    logic [31:0] rd = '0;
    logic er = 1'b0;
    int idx = int'(a - 16'h4000) >> 10;
    logic [7:0] esel = 8'(1 << idx);
    cpu_addr = a; cpu_write = w; cpu_wdata = d; cpu_req = 1'b1;
    @(posedge clk); #2;
    if (mode == 2) begin
      cpu_addr = 16'h4C44; cpu_wdata = 32'hDEAD_BEEF; cpu_write = ~w;
    end else cpu_req = 1'b0;
    for (int k = 1; k <= 40 && !got; k++) begin
      if (k > 1) begin @(posedge clk); #2; end
      if (mode == 1 && k == 2) cfg_div = 5'(new_div);
      cyc = k;
      if (cpu_wait) waits++;
      if (per_clk_en) ens++;
      if (per_sel !== esel || per_addr !== a[9:0] || per_we !== w) bad++;
      if (w && per_wdata !== d) bad++;
      if (cpu_ready) begin got = 1; rd = cpu_rdata; er = cpu_err; end
    end
    cpu_req = 1'b0;
    check(cyc == exp_n, "R3", {req, " access length"}, cyc, exp_n);
    check(waits == exp_n - 1, "R3", {req, " wait cycles"}, waits, exp_n - 1);
    check(bad == 0, (mode == 2) ? "R9" : (w ? "R7" : "R2"),
          {req, " select/offset/we/wdata per cycle"}, bad, 0);
    check(ens == 1 && er == 1'b0, "R10", {req, " one enable, no error"}, ens, 1);
    if (!w) check(rd == (32'hC000_0000 | (32'(idx) << 16) | 32'(a[9:0])), "R6",
                  {req, " read data"}, rd, 32'hC000_0000 | (32'(idx) << 16) | 32'(a[9:0]));
    @(posedge clk); #2;
    check(per_sel == 8'h0 && !cpu_ready && !cpu_wait, (mode == 2) ? "R9" : "R3",
          {req, " idle after access"}, per_sel, 0);
  endtask

  task automatic t_reset;
    check(per_sel == 8'h0 && !per_we && !per_clk_en, "R1", "peripheral side after reset",
          {per_sel, per_we, per_clk_en}, 0);
    check(!cpu_wait && !cpu_ready && !cpu_err, "R1", "cpu side after reset",
          {cpu_wait, cpu_ready, cpu_err}, 0);
  endtask

  task automatic t_reads;
    cfg_div = 5'd2;  access(16'h4000, 1'b0, '0, 2, 0, 0, "R2 read region0 div2");
    cfg_div = 5'd16; access(16'h5FFC, 1'b0, '0, 16, 0, 0, "R2 read region7 div16");
    cfg_div = 5'd5;  access(16'h4D2A, 1'b0, '0, 5, 0, 0, "R6 read region3 div5");
  endtask

  task automatic t_writes;
    cfg_div = 5'd3; access(16'h5404, 1'b1, 32'h1234_5678, 3, 0, 0, "R7 write region5 div3");
    cfg_div = 5'd7; access(16'h4BFF, 1'b1, 32'hA5A5_0F0F, 7, 0, 0, "R7 write region2 div7");
  endtask

  task automatic t_clamp;
    cfg_div = 5'd0;  access(16'h4400, 1'b0, '0, exp_div(0), 0, 0, "R4 div0");
    cfg_div = 5'd1;  access(16'h4800, 1'b0, '0, exp_div(1), 0, 0, "R4 div1");
    cfg_div = 5'd17; access(16'h5000, 1'b0, '0, exp_div(17), 0, 0, "R4 div17");
    cfg_div = 5'd31; access(16'h5800, 1'b1, 32'h0BAD_F00D, exp_div(31), 0, 0, "R4 div31");
  endtask

  task automatic t_div_change;
    cfg_div = 5'd4; access(16'h4404, 1'b0, '0, 4, 1, 9, "R5 change mid-access");
    access(16'h4408, 1'b0, '0, 9, 0, 0, "R5 next uses new div");
  endtask

  task automatic t_busy;
    cfg_div = 5'd6; access(16'h5C10, 1'b0, '0, 6, 2, 0, "R9 requests while busy");
    cfg_div = 5'd2; access(16'h4020, 1'b1, 32'h55AA_55AA, 2, 2, 0, "R9 requests while busy div2");
  endtask

  task automatic t_err(input logic [15:0] a);
    cpu_addr = a; cpu_write = 1'b0; cpu_req = 1'b1;
    @(posedge clk); #2;
    cpu_req = 1'b0;
    check(cpu_ready && cpu_err && per_sel == 8'h0 && !cpu_wait && !per_clk_en, "R8",
          "decode error response", {cpu_ready, cpu_err, per_sel, cpu_wait, per_clk_en},
          {1'b1, 1'b1, 8'h0, 1'b0, 1'b0});
    @(posedge clk); #2;
    check(!cpu_ready && !cpu_err && per_sel == 8'h0, "R8", "idle after error",
          {cpu_ready, cpu_err, per_sel}, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    rst_n = 1'b1;
    @(posedge clk); #2;
    t_reset();
    t_reads();
    t_writes();
    t_clamp();
    t_div_change();
    t_busy();
    t_err(16'h3FFF);
    t_err(16'h6000);
    t_err(16'h0000);
    cfg_div = 5'd3; access(16'h4C00, 1'b0, '0, 3, 0, 0, "R10 access after errors");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule